// File: doc/BRIEF.md
# Raw Pixel Capture Front End with Frame-Start Lock

This block captures a raw pixel bus and passes it on without reading any meaning into the data. On every clock in which the capture-enable input is high, the block takes one sample from the 10-bit pixel bus and pushes it into a small output queue. The queue drains over a valid/ready stream. Capture ends once a programmed total number of samples has been taken. The source has no separate frame or line sync pins. The capture-enable input is usually a line-valid strobe that stays low during vertical blanking.

When the lock option is on, the block starts by measuring how long capture-enable stays low. Any low stretch that lasts at least a programmable threshold counts as a blanking gap. Capture starts only after two such gaps, so the first stored sample is the first pixel of a frame. This lock is made once per enable. To lock again, the port must be disabled and then enabled. Status pins show whether the block is waiting for lock, capturing, or complete. A sticky flag reports samples that were lost to back-pressure.

The output stream follows these rules. `out_valid` stays high and `out_data` stays fixed until the sink accepts the sample with `out_ready`. The source cannot be stalled. If a sample arrives while the queue is full and no word leaves in that cycle, the sample is dropped. It still counts toward the stop total.

Top module: `raw_capture_port`

## Requirements
- R1: While `cfg_enable` is low, one clock later `sts_waiting`, `sts_capturing`, `sts_done` and `out_valid` are all low, and the queue and sample count are cleared. `sts_overrun` is also low.
- R2: With lock off, the block enters capture one clock after `cfg_enable` is first seen high. It then stores the pixel bus on every later clock with `cap_en` high, in arrival order. Clocks with `cap_en` low store nothing.
- R3: The stop total is `{cfg_stop_y, cfg_stop_x}`, with Y as the upper 12 bits. After exactly that many samples, `sts_done` rises. A total of 0 completes with no sample taken.
- R4: `sts_done` stays high and all further pixel data is ignored until `cfg_enable` goes low. A new enable then starts a fresh run.
- R5: With lock on, `sts_waiting` is high and nothing is stored until two `cap_en` low stretches of at least `cfg_vblank_thr` cycles have been seen. Shorter low stretches do not count. Capture starts on the first `cap_en` high cycle after the second gap.
- R6: Low-time measurement begins after enable. A `cap_en` level that is already high at enable is neither stored nor counted as part of a gap.
- R7: Lock happens only once per enable. Long low stretches during capture do not pause or restart the capture.
- R8: A threshold of 0 behaves as a threshold of 1.
- R9: With `cfg_mode8` high, each stored word is `{2'b00, pix_in[9:2]}`. With it low, the word is `pix_in` unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is stable. A sample that arrives with the queue full, and with no word leaving in that cycle, is dropped but still counted. It sets `sts_overrun`, which stays high until disable.
- R11: At most one of `sts_waiting`, `sts_capturing`, `sts_done` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable; low clears the run |
| cfg_sync_en | input | 1 | Frame-start lock on |
| cfg_mode8 | input | 1 | Store the upper 8 bits only |
| cfg_vblank_thr | input | 12 | Minimum low time, in clocks, that counts as a blanking gap |
| cfg_stop_x | input | 12 | Lower 12 bits of the stop total |
| cfg_stop_y | input | 12 | Upper 12 bits of the stop total |
| cap_en | input | 1 | Capture-enable (line-valid style) |
| pix_in | input | 10 | Raw pixel bus |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 10 | Stream word |
| sts_waiting | output | 1 | Waiting for frame-start lock |
| sts_capturing | output | 1 | Capture in progress |
| sts_done | output | 1 | Stop total reached (sticky) |
| sts_overrun | output | 1 | A sample was dropped (sticky) |

## Verification
The bench builds the block with its default parameters: a 10-bit pixel bus, 12-bit threshold and stop fields, and a 4-entry queue. A Y field of 1 drives the 24-bit counter past the 12-bit boundary, to a total of 4096 samples, in a few thousand clocks. The 4-entry queue lets a short burst with `out_ready` held low reach the drop path. The 12-bit threshold is set to small values, 0 and 5, so that both qualifying and too-short low stretches occur within a few cycles.

// File: rtl/raw_cap_pkg.sv
package raw_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/rc_gap_detect.sv
// Measures cap_en low stretches while active; reports when the GAPS-th
// qualifying stretch completes.
module rc_gap_detect #(
  parameter int THR_W = 12,
  parameter int GAPS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cap_en,
  input  logic [THR_W-1:0] thr,
  output logic             lock_now
);
  localparam int GC_W = $clog2(GAPS + 1);
  localparam logic [THR_W-1:0] RUN_MAX = '1;

  logic [THR_W-1:0] low_run_q;
  logic [GC_W-1:0]  gaps_q;
  logic [THR_W-1:0] thr_eff;
  logic [THR_W:0]   run_plus;
  logic             qualify;

  // a zero threshold is treated as one cycle
  assign thr_eff  = (thr == '0) ? THR_W'(1) : thr;
  assign run_plus = {1'b0, low_run_q} + 1'b1;
  assign qualify  = active && !cap_en && (run_plus == {1'b0, thr_eff});
  assign lock_now = qualify && (gaps_q == GC_W'(GAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      gaps_q    <= '0;
    end else if (!active) begin
      low_run_q <= '0;
      gaps_q    <= '0;
    end else begin
      if (cap_en)
        low_run_q <= '0;
      else if (low_run_q != RUN_MAX)
        low_run_q <= low_run_q + 1'b1;
      if (qualify && gaps_q != GC_W'(GAPS))
        gaps_q <= gaps_q + 1'b1;
    end
  end
endmodule

// File: rtl/rc_sample_count.sv
// Counts taken samples and flags the one that reaches the stop total.
module rc_sample_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] stop,
  output logic             last,
  output logic             stop_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next  = cnt_q + 1'b1;
  assign last      = inc && (cnt_next == stop);
  assign stop_zero = (stop == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_next;
  end
endmodule

// File: rtl/rc_out_fifo.sv
// Small output queue with valid/ready read side; drops on full push.
module rc_out_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         drop,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop, wr_ok;

  assign full      = (cnt_q == CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && out_ready;
  assign wr_ok     = push && (!full || pop);
  assign drop      = push && full && !pop;
  assign out_data  = mem_q[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= bump(wr_q);
      if (pop)   rd_q <= bump(rd_q);
      case ({wr_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && wr_q == AW'(i)) mem_q[i] <= din;
    end
  end
endmodule

// File: rtl/raw_capture_port.sv
module raw_capture_port
  import raw_cap_pkg::*;
#(
  parameter int PIX_W      = 10,
  parameter int FIELD_W    = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_sync_en,
  input  logic               cfg_mode8,
  input  logic [FIELD_W-1:0] cfg_vblank_thr,
  input  logic [FIELD_W-1:0] cfg_stop_x,
  input  logic [FIELD_W-1:0] cfg_stop_y,
  input  logic               cap_en,
  input  logic [PIX_W-1:0]   pix_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_data,
  output logic               sts_waiting,
  output logic               sts_capturing,
  output logic               sts_done,
  output logic               sts_overrun
);
  localparam int CNT_W    = 2 * FIELD_W;
  localparam int NARROW_W = 8;
  localparam int PAD_W    = PIX_W - NARROW_W;

  cap_state_e       state_q, state_d;
  logic             lock_now, take, last, stop_zero, drop, overrun_q;
  logic [CNT_W-1:0] stop_total;
  logic [PIX_W-1:0] word;

  assign stop_total = {cfg_stop_y, cfg_stop_x};
  assign take       = (state_q == ST_CAPT) && cap_en && !stop_zero;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = cfg_mode8 ? {{PAD_W{1'b0}}, pix_in[PIX_W-1 -: NARROW_W]} : pix_in;
    end else begin : g_nopad
      assign word = pix_in;
    end
  endgenerate

  rc_gap_detect #(.THR_W(FIELD_W), .GAPS(2)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == ST_LOCK),
    .cap_en   (cap_en),
    .thr      (cfg_vblank_thr),
    .lock_now (lock_now)
  );

  rc_sample_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!cfg_enable),
    .inc       (take),
    .stop      (stop_total),
    .last      (last),
    .stop_zero (stop_zero)
  );

  rc_out_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!cfg_enable),
    .push      (take),
    .din       (word),
    .drop      (drop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always_comb begin
    state_d = state_q;
    if (!cfg_enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = cfg_sync_en ? ST_LOCK : ST_CAPT;
        ST_LOCK: if (lock_now) state_d = ST_CAPT;
        ST_CAPT: if (stop_zero || last) state_d = ST_DONE;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!cfg_enable) overrun_q <= 1'b0;
      else if (drop)   overrun_q <= 1'b1;
    end
  end

  assign sts_waiting   = (state_q == ST_LOCK);
  assign sts_capturing = (state_q == ST_CAPT);
  assign sts_done      = (state_q == ST_DONE);
  assign sts_overrun   = overrun_q;
endmodule

// File: rtl/raw_capture_port_chk.sv
module raw_capture_port_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             sts_waiting,
  input logic             sts_capturing,
  input logic             sts_done,
  input logic             sts_overrun
);
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !out_valid && !sts_waiting && !sts_capturing && !sts_done && !sts_overrun); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_done && cfg_enable |=> sts_done); // R4
  AST_NO_DATA_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sts_waiting |-> !out_valid); // R5
  AST_LOCK_LEADS_TO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_waiting) && cfg_enable |-> sts_capturing); // R5
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && cfg_enable |=> out_valid && $stable(out_data)); // R10
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_waiting, sts_capturing, sts_done})); // R11
endmodule

bind raw_capture_port raw_capture_port_chk #(.PIX_W(PIX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .sts_waiting   (sts_waiting),
  .sts_capturing (sts_capturing),
  .sts_done      (sts_done),
  .sts_overrun   (sts_overrun)
);

// File: tb/raw_capture_port_test.sv
`timescale 1ns/1ps
module raw_capture_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_sync_en = 1'b0, cfg_mode8 = 1'b0;
  logic [11:0] cfg_vblank_thr = '0, cfg_stop_x = '0, cfg_stop_y = '0;
  logic        cap_en = 1'b0;
  logic [9:0]  pix_in = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [9:0]  out_data;
  logic        sts_waiting, sts_capturing, sts_done, sts_overrun;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [9:0] rx[$];
  logic [9:0] exp_q[$];

  always #10 clk = ~clk;

  raw_capture_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sync_en(cfg_sync_en),
    .cfg_mode8(cfg_mode8), .cfg_vblank_thr(cfg_vblank_thr), .cfg_stop_x(cfg_stop_x),
    .cfg_stop_y(cfg_stop_y), .cap_en(cap_en), .pix_in(pix_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .sts_waiting(sts_waiting),
    .sts_capturing(sts_capturing), .sts_done(sts_done), .sts_overrun(sts_overrun)
  );

  always @(negedge clk) if (out_valid && out_ready) rx.push_back(out_data);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic chk_stream(input string req);
    chk(rx.size() == exp_q.size(), req, "sample count", rx.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx.size(); i++)
      chk(rx[i] == exp_q[i], req, $sformatf("sample %0d", i), rx[i], exp_q[i]);
  endtask

  task automatic cyc(input logic en, input logic [9:0] d);
    cap_en = en;
    pix_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 10'd0);
  endtask

  task automatic highs(input int n, input int base);
    for (int i = 0; i < n; i++) cyc(1'b1, 10'(base + i));
  endtask

  task automatic port_off();
    cfg_enable = 1'b0;
    lows(2);
    rx.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    chk(!out_valid && !sts_waiting && !sts_capturing && !sts_done && !sts_overrun,
        "R1", "reset outputs", {out_valid, sts_waiting, sts_capturing, sts_done}, 0);
  endtask

  task automatic t_plain();
    cfg_sync_en = 0; cfg_mode8 = 0; cfg_stop_y = 0; cfg_stop_x = 6; out_ready = 1;
    cfg_enable = 1;
    lows(1);
    chk(sts_capturing, "R2", "capturing after enable", sts_capturing, 1);
    highs(3, 10); lows(2); highs(4, 20); lows(3);
    exp_q = '{10'd10, 10'd11, 10'd12, 10'd20, 10'd21, 10'd22};
    chk_stream("R2");
    chk(sts_done, "R3", "done after six", sts_done, 1);
    highs(3, 30); lows(3);
    chk(rx.size() == 6, "R4", "data ignored after done", rx.size(), 6);
    chk(sts_done, "R4", "done sticky", sts_done, 1);
    cfg_enable = 0;
    lows(1);
    chk(!sts_done && !sts_capturing && !out_valid, "R1", "disable clears",
        {sts_done, sts_capturing, out_valid}, 0);
    port_off();
    cfg_enable = 1;
    lows(1);
    highs(2, 40); lows(2);
    exp_q = '{10'd40, 10'd41};
    chk_stream("R4");
    port_off();
  endtask

  task automatic t_stop_y();
    cfg_stop_y = 12'd1; cfg_stop_x = 12'd0;
    cfg_enable = 1;
    lows(1);
    highs(4200, 0); lows(3);
    chk(rx.size() == 4096, "R3", "Y field total", rx.size(), 4096);
    if (rx.size() == 4096) chk(rx[4095] == 10'd1023, "R3", "last sample", rx[4095], 1023);
    chk(sts_done, "R3", "done at 4096", sts_done, 1);
    port_off();
  endtask

  task automatic t_stop_zero();
    cfg_stop_y = 0; cfg_stop_x = 0;
    cfg_enable = 1;
    lows(1);
    highs(2, 5); lows(2);
    chk(sts_done && rx.size() == 0, "R3", "zero total", rx.size(), 0);
    port_off();
  endtask

  task automatic t_lock();
    cfg_sync_en = 1; cfg_vblank_thr = 12'd5; cfg_stop_y = 0; cfg_stop_x = 8;
    highs(2, 900);
    cfg_enable = 1;
    highs(4, 910);  // high at enable: R6
    lows(3); highs(4, 920); lows(6); highs(4, 100); lows(3);
    chk(sts_waiting && !sts_capturing && !sts_done, "R5", "still waiting after one gap",
        {sts_waiting, sts_capturing, sts_done}, 4);
    chk(rx.size() == 0, "R6", "nothing stored before lock", rx.size(), 0);
    highs(2, 110); lows(8);
    chk(sts_capturing && !sts_waiting, "R5", "locked after second gap",
        {sts_waiting, sts_capturing}, 1);
    highs(4, 200); lows(10); highs(4, 204); lows(3);
    exp_q = '{10'd200, 10'd201, 10'd202, 10'd203, 10'd204, 10'd205, 10'd206, 10'd207};
    chk_stream("R7");
    chk(sts_done && !sts_waiting, "R11", "done only", {sts_waiting, sts_done}, 1);
    port_off();
  endtask

  task automatic t_thr_zero();
    cfg_sync_en = 1; cfg_vblank_thr = 12'd0; cfg_stop_y = 0; cfg_stop_x = 2;
    highs(1, 0);
    cfg_enable = 1;
    highs(1, 0); lows(1); highs(1, 50); lows(1); highs(2, 60); lows(3);
    exp_q = '{10'd60, 10'd61};
    chk_stream("R8");
    chk(sts_done, "R8", "done", sts_done, 1);
    port_off();
  endtask

  task automatic t_mode8();
    cfg_sync_en = 0; cfg_mode8 = 1; cfg_stop_y = 0; cfg_stop_x = 2;
    cfg_enable = 1;
    lows(1);
    cyc(1'b1, 10'h3A7); cyc(1'b1, 10'h155); lows(3);
    exp_q = '{10'h0E9, 10'h055};
    chk_stream("R9");
    cfg_mode8 = 0;
    port_off();
  endtask

  task automatic t_stall();
    cfg_sync_en = 0; cfg_stop_y = 0; cfg_stop_x = 6; out_ready = 0;
    cfg_enable = 1;
    lows(1);
    highs(6, 1); lows(2);
    chk(out_valid && out_data == 10'd1, "R10", "head held", out_data, 1);
    chk(sts_overrun, "R10", "overrun flagged", sts_overrun, 1);
    chk(sts_done, "R10", "dropped samples counted", sts_done, 1);
    lows(3);
    chk(out_valid && out_data == 10'd1, "R10", "head stable", out_data, 1);
    out_ready = 1;
    lows(6);
    exp_q = '{10'd1, 10'd2, 10'd3, 10'd4};
    chk_stream("R10");
    chk(sts_overrun, "R10", "overrun sticky", sts_overrun, 1);
    port_off();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    lows(1);
    t_reset();
    t_plain();
    t_stop_y();
    t_stop_zero();
    t_lock();
    t_thr_zero();
    t_mode8();
    t_stall();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule